// File: doc/BRIEF.md
# Indirect Register Access Window

This block gives a host a narrow path into a wide internal register space. The host sees a small 32-bit register interface with three live offsets: a control register that holds an access-enable bit, an address pointer, and a data port. The host loads the pointer with the byte address of an internal 32-bit register. Its accesses to the data port then turn into single-cycle reads and writes on a word-addressed internal register bus.

The pointer keeps only a word-aligned field. Its two low bits and its high bits read back as zero and cannot be written. The window is closed while the enable bit is clear. In that state data-port writes never reach the internal bus and data-port reads return zero, while the pointer stays usable. Internal writes start in the same cycle as the host write. Host reads return through a register one cycle after the read strobe, marked by a one-cycle valid pulse.

Top module: `indirect_reg_window`

## Requirements
- R1: The control register sits at host offset 0x68. Bit 7 is the enable bit, it is written from byte lane 0 only when host_be[0] is set, and it resets to 0. All other bits read as zero.
- R2: The pointer register sits at host offset 0x78 and stores only byte-address bits 17:2. Bits 1:0 and 31:18 always read as zero, and writing them has no effect.
- R3: After reset the pointer reads as zero, and it changes only on a host write to offset 0x78.
- R4: A data-port write (offset 0x80) with the window enabled and at least one byte enable set drives int_wr high in that same cycle. In that cycle int_addr equals pointer bits 17:2, int_wdata equals host_wdata, and int_be equals host_be bit for bit (int_be[n] gates byte n, bits 8n+7:8n).
- R5: A data-port read with the window enabled drives int_rd in that same cycle with int_addr equal to pointer bits 17:2. The int_rdata value of that cycle appears on host_rdata in the following cycle.
- R6: A data-port write with host_be equal to 4'b0000 produces no internal write.
- R7: While the enable bit is 0, data-port writes produce no int_wr and data-port reads produce no int_rd and return zero. The pointer can still be written and read.
- R8: Every host read cycle is followed, one cycle later, by exactly one cycle of host_rvalid high, with the read result on host_rdata. No host_rvalid appears without a host read.
- R9: Host reads of any offset other than 0x68, 0x78 and 0x80 return zero, and host writes to them change no state and cause no internal access.
- R10: Writes to the pointer and control registers update a byte lane only when that lane's host_be bit is set. The pointer's stored bits 7:2 come from lane 0, bits 15:8 from lane 1 and bits 17:16 from lane 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_addr | input | 8 | Host byte offset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| int_addr | output | 16 | Internal word address (pointer bits 17:2) |
| int_wr | output | 1 | Internal write strobe |
| int_be | output | 4 | Internal byte enables |
| int_wdata | output | 32 | Internal write data |
| int_rd | output | 1 | Internal read strobe |
| int_rdata | input | 32 | Internal read data, valid in the int_rd cycle |

## Verification
The assertions assume that the host never raises host_wr and host_rd in the same cycle. One of them flags such a cycle as an input violation. They also assume that int_rdata is valid combinationally in the cycle int_rd is high. The bench drives one host command per cycle from tasks, at the falling edge. Its internal register model answers reads from the current address with no wait. The bench therefore never leaves the single-command, zero-latency envelope the checks rely on.

// File: rtl/irw_pkg.sv
package irw_pkg;
  localparam logic [7:0]  OFS_CTRL = 8'h68;
  localparam logic [7:0]  OFS_PTR  = 8'h78;
  localparam logic [7:0]  OFS_DATA = 8'h80;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned PTR_LSB  = 2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_PTR,
    SEL_DATA
  } irw_sel_e;
endpackage

// File: rtl/irw_addr_decode.sv
module irw_addr_decode #(
  parameter int unsigned HOST_AW = 8
) (
  input  logic [HOST_AW-1:0] host_addr,
  output irw_pkg::irw_sel_e  sel
);
  import irw_pkg::*;

  always_comb begin
    if (host_addr == HOST_AW'(OFS_CTRL))      sel = SEL_CTRL;
    else if (host_addr == HOST_AW'(OFS_PTR))  sel = SEL_PTR;
    else if (host_addr == HOST_AW'(OFS_DATA)) sel = SEL_DATA;
    else                                      sel = SEL_NONE;
  end
endmodule

// File: rtl/irw_host_regs.sv
module irw_host_regs #(
  parameter int unsigned PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ctrl_wdata,
  input  logic             ptr_wr,
  input  logic [PTR_W-1:0] ptr_bit_en,
  input  logic [PTR_W-1:0] ptr_wdata,
  output logic             en,
  output logic [PTR_W-1:0] ptr_word
);
  logic             en_d;
  logic [PTR_W-1:0] ptr_d;

  // next-state
  always_comb begin
    en_d = en;
    if (ctrl_wr) en_d = ctrl_wdata;
  end

  always_comb begin
    ptr_d = ptr_word;
    if (ptr_wr) ptr_d = (ptr_bit_en & ptr_wdata) | (~ptr_bit_en & ptr_word);
  end

  // registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en <= 1'b0;
    else if (ctrl_wr) en <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_word <= '0;
    else if (ptr_wr) ptr_word <= ptr_d;
  end

  // R3: pointer holds unless written
  a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_wr |=> $stable(ptr_word));

  // R10: bits outside enabled lanes never change on a pointer write
  a_r10_ptr_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> ((ptr_word ^ $past(ptr_word)) & ~$past(ptr_bit_en)) == '0);

  // R1: enable bit holds unless its lane is written
  a_r1_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(en));
endmodule

// File: rtl/irw_bus_master.sv
module irw_bus_master #(
  parameter int unsigned PTR_W = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned BE_W = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irw_pkg::irw_sel_e sel,
  input  logic              en,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BE_W-1:0]   host_be,
  input  logic [DW-1:0]     host_wdata,
  input  logic [PTR_W-1:0]  ptr_word,
  output logic [PTR_W-1:0]  int_addr,
  output logic              int_wr,
  output logic [BE_W-1:0]   int_be,
  output logic [DW-1:0]     int_wdata,
  output logic              int_rd
);
  import irw_pkg::*;

  logic port_hit;

  always_comb begin
    port_hit  = (sel == SEL_DATA) && en;
    int_addr  = ptr_word;
    int_be    = host_be;
    int_wdata = host_wdata;
    int_wr    = port_hit && host_wr && (host_be != '0);
    int_rd    = port_hit && host_rd;
  end

  // input envelope: one host command per cycle
  a_in_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_rd));

  // R6: no internal write without a byte enable
  a_r6_no_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
    int_wr |-> (host_be != '0));

  // R7: closed window issues nothing
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!int_wr && !int_rd));

  // R4: internal write targets the stored pointer
  a_r4_target: assert property (@(posedge clk) disable iff (!rst_n)
    int_wr |-> (host_wr && int_addr == ptr_word));
endmodule

// File: rtl/irw_read_return.sv
module irw_read_return #(
  parameter int unsigned PTR_W = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned PTR_MSB = irw_pkg::PTR_LSB + PTR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  irw_pkg::irw_sel_e sel,
  input  logic              en,
  input  logic [PTR_W-1:0]  ptr_word,
  input  logic [DW-1:0]     int_rdata,
  output logic [DW-1:0]     host_rdata,
  output logic              host_rvalid
);
  import irw_pkg::*;

  logic [DW-1:0] ctrl_view;
  logic [DW-1:0] ptr_view;
  logic [DW-1:0] rdata_d;

  always_comb begin
    ctrl_view         = '0;
    ctrl_view[EN_BIT] = en;
    ptr_view          = '0;
    ptr_view[PTR_MSB:PTR_LSB] = ptr_word;
    unique case (sel)
      SEL_CTRL: rdata_d = ctrl_view;
      SEL_PTR:  rdata_d = ptr_view;
      SEL_DATA: rdata_d = en ? int_rdata : '0;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_rvalid <= 1'b0;
    else        host_rvalid <= host_rd;
  end

  // R8: valid follows every read, and only reads
  a_r8_valid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !host_rvalid);

  // R2: reserved pointer bits read zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && $past(sel == SEL_PTR)) |->
      (host_rdata[PTR_LSB-1:0] == '0 && host_rdata[DW-1:PTR_MSB+1] == '0));

  // R9: unmapped offsets read zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && $past(sel == SEL_NONE)) |-> host_rdata == '0);

  // R7: closed window data read returns zero
  a_r7_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && $past(sel == SEL_DATA && !en)) |-> host_rdata == '0);
endmodule

// File: rtl/indirect_reg_window.sv
module indirect_reg_window #(
  parameter int unsigned HOST_AW = 8,
  parameter int unsigned PTR_W   = 16,
  parameter int unsigned DW      = 32,
  localparam int unsigned BE_W    = DW / 8,
  localparam int unsigned PTR_MSB = irw_pkg::PTR_LSB + PTR_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [BE_W-1:0]    host_be,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  output logic               host_rvalid,
  output logic [PTR_W-1:0]   int_addr,
  output logic               int_wr,
  output logic [BE_W-1:0]    int_be,
  output logic [DW-1:0]      int_wdata,
  output logic               int_rd,
  input  logic [DW-1:0]      int_rdata
);
  import irw_pkg::*;

  irw_sel_e         sel;
  logic             en;
  logic [PTR_W-1:0] ptr_word;
  logic [PTR_W-1:0] ptr_bit_en;
  logic             ptr_wr;
  logic             ctrl_wr;

  irw_addr_decode #(.HOST_AW(HOST_AW)) u_decode (
    .host_addr (host_addr),
    .sel       (sel)
  );

  // per-bit lane enables for the stored pointer field
  for (genvar i = 0; i < PTR_W; i++) begin : g_ptr_lane
    assign ptr_bit_en[i] = host_be[(i + PTR_LSB) / 8];
  end

  assign ptr_wr  = host_wr && (sel == SEL_PTR);
  assign ctrl_wr = host_wr && (sel == SEL_CTRL) && host_be[EN_BIT / 8];

  irw_host_regs #(.PTR_W(PTR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (host_wdata[EN_BIT]),
    .ptr_wr     (ptr_wr),
    .ptr_bit_en (ptr_bit_en),
    .ptr_wdata  (host_wdata[PTR_MSB:PTR_LSB]),
    .en         (en),
    .ptr_word   (ptr_word)
  );

  irw_bus_master #(.PTR_W(PTR_W), .DW(DW)) u_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .en         (en),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_be    (host_be),
    .host_wdata (host_wdata),
    .ptr_word   (ptr_word),
    .int_addr   (int_addr),
    .int_wr     (int_wr),
    .int_be     (int_be),
    .int_wdata  (int_wdata),
    .int_rd     (int_rd)
  );

  irw_read_return #(.PTR_W(PTR_W), .DW(DW)) u_rret (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rd     (host_rd),
    .sel         (sel),
    .en          (en),
    .ptr_word    (ptr_word),
    .int_rdata   (int_rdata),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid)
  );

  // R1: a closed window only opens through a lane-0 control write
  a_r1_open_by_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> $past(host_wr && sel == SEL_CTRL && host_be[EN_BIT / 8]));
endmodule

// File: tb/test_indirect_reg_window.sv
module test_indirect_reg_window;
  logic        clk;
  logic        rst_n;
  logic [7:0]  host_addr;
  logic        host_wr;
  logic        host_rd;
  logic [3:0]  host_be;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic [15:0] int_addr;
  logic        int_wr;
  logic [3:0]  int_be;
  logic [31:0] int_wdata;
  logic        int_rd;
  logic [31:0] int_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int wr_cnt  = 0;
  int rd_cnt  = 0;

  logic [31:0] mem     [64];
  logic [31:0] exp_mem [64];

  logic        cap_wr, cap_rd;
  logic [15:0] cap_addr;
  logic [3:0]  cap_be;
  logic [31:0] cap_wdata;

  indirect_reg_window i_indirect_reg_window (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_be(host_be), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .int_addr(int_addr),
    .int_wr(int_wr), .int_be(int_be), .int_wdata(int_wdata), .int_rd(int_rd),
    .int_rdata(int_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] init_val(input int i);
    return 32'h3C00_0000 ^ (i * 32'h0101_0F07);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 4; b++) if (be[b]) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  // internal register file model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_val(i);
    end else if (int_wr) begin
      for (int b = 0; b < 4; b++)
        if (int_be[b]) mem[int_addr[5:0]][8*b +: 8] <= int_wdata[8*b +: 8];
    end
  end
  assign int_rdata = mem[int_addr[5:0]];

  always @(posedge clk) begin
    if (rst_n && int_wr) wr_cnt++;
    if (rst_n && int_rd) rd_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_be = be; host_wdata = d; host_wr = 1'b1;
    #1;
    cap_wr = int_wr; cap_addr = int_addr; cap_be = int_be; cap_wdata = int_wdata;
    @(negedge clk);
    host_wr = 1'b0; host_be = 4'h0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1;
    cap_rd = int_rd; cap_addr = int_addr;
    @(negedge clk);
    host_rd = 1'b0;
    chk(host_rvalid === 1'b1, "R8 rvalid after read", 32'(host_rvalid), 32'h1);
    d = host_rdata;
    #1;
    @(negedge clk);
    chk(host_rvalid === 1'b0, "R8 single rvalid pulse", 32'(host_rvalid), 32'h0);
  endtask

  initial begin
    logic [31:0] r, v, e, d;
    logic [15:0] wa;
    logic [3:0]  be;
    int          wc0, rc0;
    rst_n = 1'b0; host_addr = '0; host_wr = 1'b0; host_rd = 1'b0;
    host_be = '0; host_wdata = '0;
    for (int i = 0; i < 64; i++) exp_mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    chk(host_rvalid === 1'b0 && host_rdata === 32'h0, "R8 reset outputs", host_rdata, 32'h0);
    chk(int_wr === 1'b0 && int_rd === 1'b0, "R7 no access in reset", {int_wr, int_rd}, 32'h0);
    rst_n = 1'b1;

    hread(8'h68, r); chk(r === 32'h0, "R1 control resets to zero", r, 32'h0);
    hread(8'h78, r); chk(r === 32'h0, "R3 pointer resets to zero", r, 32'h0);

    // R9: every unmapped offset ignores writes and reads zero
    for (int a = 0; a < 256; a++) begin
      if (a == 'h68 || a == 'h78 || a == 'h80) continue;
      hwrite(8'(a), 4'hF, 32'hFFFF_FFFF);
      chk(cap_wr === 1'b0, "R9 unmapped write no int_wr", 32'(cap_wr), 32'h0);
      hread(8'(a), r);
      chk(r === 32'h0, "R9 unmapped read zero", r, 32'h0);
    end
    hread(8'h68, r); chk(r === 32'h0, "R9 control untouched", r, 32'h0);
    hread(8'h78, r); chk(r === 32'h0, "R9 pointer untouched", r, 32'h0);
    chk(wr_cnt == 0 && rd_cnt == 0, "R9 no internal access", 32'(wr_cnt + rd_cnt), 32'h0);

    // R7: closed window
    hwrite(8'h78, 4'hF, 32'h0000_0014);
    hread(8'h78, r); chk(r === 32'h14, "R7 pointer usable while closed", r, 32'h14);
    wc0 = wr_cnt; rc0 = rd_cnt;
    hwrite(8'h80, 4'hF, 32'hDEAD_BEEF);
    chk(cap_wr === 1'b0 && wr_cnt == wc0, "R7 closed write dropped", 32'(cap_wr), 32'h0);
    hread(8'h80, r);
    chk(r === 32'h0, "R7 closed read zero", r, 32'h0);
    chk(cap_rd === 1'b0 && rd_cnt == rc0, "R7 closed read no int_rd", 32'(cap_rd), 32'h0);
    hread(8'h78, r); chk(r === 32'h14, "R7 pointer kept", r, 32'h14);
    chk(mem[5] === init_val(5), "R7 internal reg unchanged", mem[5], init_val(5));

    // R1/R10: control write needs lane 0
    hwrite(8'h68, 4'hE, 32'hFFFF_FFFF);
    hread(8'h68, r); chk(r === 32'h0, "R10 control lane0 disabled", r, 32'h0);
    hwrite(8'h68, 4'hF, 32'hFFFF_FFFF);
    hread(8'h68, r); chk(r === 32'h80, "R1 enable bit only", r, 32'h80);
    hwrite(8'h68, 4'h1, 32'h0000_007F);
    hread(8'h68, r); chk(r === 32'h0, "R1 enable cleared by bit7=0", r, 32'h0);
    hwrite(8'h68, 4'h1, 32'h0000_0080);
    hread(8'h68, r); chk(r === 32'h80, "R1 enable set", r, 32'h80);

    // R2/R10: pointer lane sweep
    for (int k = 0; k < 2; k++) begin
      v = (k == 0) ? 32'hFFFF_FFFF : 32'hA5A5_A5A7;
      for (int b = 0; b < 16; b++) begin
        hwrite(8'h78, 4'hF, 32'h0);
        hwrite(8'h78, 4'(b), v);
        e = v & lane_mask(4'(b)) & 32'h0003_FFFC;
        hread(8'h78, r);
        chk(r === e, "R2 R10 pointer lanes and reserved bits", r, e);
      end
    end

    // R4/R5/R6: data port sweep over 64 internal words
    for (int w = 0; w < 64; w++) begin
      wa = 16'(w) | 16'(w << 10);
      hwrite(8'h78, 4'hF, 32'hFFFC_0003 | (32'(wa) << 2));
      hread(8'h78, r);
      chk(r === (32'(wa) << 2), "R2 pointer readback", r, 32'(wa) << 2);
      be = 4'(w);
      d  = (32'(w) * 32'h0101_0101) ^ 32'h9E37_79B9;
      wc0 = wr_cnt;
      hwrite(8'h80, be, d);
      if (be == 4'h0) begin
        chk(cap_wr === 1'b0 && wr_cnt == wc0, "R6 empty-be write dropped", 32'(cap_wr), 32'h0);
      end else begin
        chk(cap_wr === 1'b1 && wr_cnt == wc0 + 1, "R4 single internal write", 32'(wr_cnt - wc0), 32'h1);
        chk(cap_addr === wa, "R4 write address", 32'(cap_addr), 32'(wa));
        chk(cap_be === be, "R4 byte enables passed", 32'(cap_be), 32'(be));
        chk(cap_wdata === d, "R4 write data passed", cap_wdata, d);
        exp_mem[w] = (exp_mem[w] & ~lane_mask(be)) | (d & lane_mask(be));
      end
      rc0 = rd_cnt;
      hread(8'h80, r);
      chk(cap_rd === 1'b1 && cap_addr === wa, "R5 internal read address", 32'(cap_addr), 32'(wa));
      chk(rd_cnt == rc0 + 1, "R5 single internal read", 32'(rd_cnt - rc0), 32'h1);
      chk(r === exp_mem[w], "R5 R6 data readback", r, exp_mem[w]);
    end

    // R7: closing the window again
    hwrite(8'h68, 4'h1, 32'h0);
    hread(8'h80, r); chk(r === 32'h0, "R7 reclosed read zero", r, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule